// File: doc/BRIEF.md
# Start-of-Frame Delimiter Detector with Timestamp Capture

This block sits after preamble synchronisation in a narrow-band receiver. It watches a stream of 4-bit symbols for a programmable one-octet start-of-frame delimiter. The delimiter is made of two symbols and closes the synchronisation header. When the delimiter is found, the block raises a one-cycle frame-start pulse. It then pairs the symbols that follow into octets for the downstream frame buffer. The delimiter itself is never forwarded as frame data. The block stays aligned until an external frame-end input sends it back to searching.

The delimiter value sits in a small register. Software can change it so that networks using a nonstandard delimiter can be received. A frame that carries any other delimiter value does not synchronise the block. If timestamping is enabled, the block latches the value of a free-running 32-bit symbol counter when the delimiter completes. It also sets a capture-valid flag, which software clears with an acknowledge.

Top module: `frame_delim_sync`

## Requirements
- R1: After reset, frame_start, octet_valid and stamp_valid are 0, stamp_value is 0, the block is searching, and the delimiter register holds 0xA7.
- R2: The delimiter's low nibble is the first symbol and its high nibble is the second. When both arrive in order on accepted symbols, frame_start is high for exactly one cycle, in the cycle after the second symbol is sampled.
- R3: If the first symbol matches but the next accepted symbol is not the high nibble, the search restarts. That symbol is itself tested as a possible first symbol.
- R4: A symbol pair that differs from the configured delimiter causes no frame_start and no octet output.
- R5: The delimiter symbols are never output as data. After frame_start, each pair of accepted symbols is output one cycle after the second symbol as octet_data = {second, first}, with octet_valid high for one cycle. A pattern equal to the delimiter inside a frame is passed on as data.
- R6: frame_end returns the block to searching and discards a pending half octet. When frame_end and a symbol arrive in the same cycle, frame_end wins and the symbol is dropped.
- R7: A cycle with cfg_wr high loads cfg_octet into the delimiter register. From then on, only the new value synchronises the block.
- R8: When stamp_en is high in the cycle that the second delimiter symbol is sampled, stamp_value takes sym_count from that cycle and stamp_valid is set, both visible one cycle later.
- R9: stamp_value keeps its value in every cycle without a capture, including delimiter matches while stamp_en is low.
- R10: stamp_ack clears stamp_valid in the next cycle. A capture in the same cycle as stamp_ack leaves stamp_valid set.
- R11: Cycles with sym_valid low do not change the search or pairing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Symbol strobe |
| sym_data | input | 4 | Received symbol |
| cfg_wr | input | 1 | Load the delimiter register |
| cfg_octet | input | 8 | New delimiter value |
| stamp_en | input | 1 | Enable timestamp capture |
| sym_count | input | 32 | Free-running symbol counter |
| stamp_ack | input | 1 | Clear capture-valid flag |
| frame_end | input | 1 | End of frame, return to search |
| frame_start | output | 1 | One-cycle pulse on delimiter match |
| octet_valid | output | 1 | Octet strobe |
| octet_data | output | 8 | Aligned frame octet |
| stamp_value | output | 32 | Captured counter value |
| stamp_valid | output | 1 | Capture-valid flag |

## Verification
On every cycle, the assertions check the following:
- frame_start never lasts two cycles and never coincides with an octet.
- frame_end always leaves the block searching.
- The timestamp moves only on a capture, and then takes the counter value from the matching cycle.
- An acknowledge without a capture clears the flag.

Some behaviour can only be shown by the bench's symbol sequences:
- the retest of a mismatched second symbol
- the rejection of a foreign delimiter
- the nibble order of output octets
- the loss of a pending half octet at frame end
- the effect of reprogramming the delimiter

// File: rtl/frame_delim_pkg.sv
// Shared types for the delimiter detector.
// Assumes: nothing beyond the 2017 language standard.
package frame_delim_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,  // waiting for first delimiter symbol
        ST_HALF   = 2'd1,  // first symbol seen, expecting second
        ST_LOCKED = 2'd2   // aligned, symbols are frame data
    } hunt_state_t;
endpackage

// File: rtl/delim_cfg_reg.sv
// Holds the programmable delimiter octet.
// Assumes: cfg_wr is a single-cycle strobe from a register interface.
module delim_cfg_reg #(
    parameter int         OCT_W     = 8,
    parameter logic [7:0] DELIM_RST = 8'hA7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [OCT_W-1:0] cfg_octet,
    output logic [OCT_W-1:0] delim
);
    // Load the delimiter on a write, return to the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      delim <= OCT_W'(DELIM_RST);
        else if (cfg_wr) delim <= cfg_octet;
    end
endmodule

// File: rtl/delim_hunter.sv
// Searches the symbol stream for the two-symbol delimiter and tracks lock.
// Assumes: the low nibble of delim arrives first; frame_end overrides symbols.
module delim_hunter
    import frame_delim_pkg::*;
#(
    parameter int SYM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic [SYM_W-1:0]   sym_data,
    input  logic [2*SYM_W-1:0] delim,
    input  logic               frame_end,
    output logic               match_now,
    output logic               locked,
    output logic               frame_start
);
    hunt_state_t state, state_nx;
    logic [SYM_W-1:0] first_sym, second_sym;
    logic             take;

    assign first_sym  = delim[SYM_W-1:0];
    assign second_sym = delim[2*SYM_W-1:SYM_W];
    assign take       = sym_valid && !frame_end;
    assign match_now  = (state == ST_HALF) && take && (sym_data == second_sym);
    assign locked     = (state == ST_LOCKED);

    // Next-state choice for the delimiter search.
    always_comb begin
        state_nx = state;
        if (frame_end) begin
            state_nx = ST_SEARCH;
        end else if (sym_valid) begin
            case (state)
                ST_SEARCH: if (sym_data == first_sym) state_nx = ST_HALF;
                ST_HALF: begin
                    if (sym_data == second_sym)     state_nx = ST_LOCKED;
                    else if (sym_data == first_sym) state_nx = ST_HALF;
                    else                            state_nx = ST_SEARCH;
                end
                default: state_nx = state;
            endcase
        end
    end

    // State register and the registered frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_SEARCH;
            frame_start <= 1'b0;
        end else begin
            state       <= state_nx;
            frame_start <= match_now;
        end
    end

    // R6
    end_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (state == ST_SEARCH));
    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

// File: rtl/octet_pairer.sv
// Pairs locked-state symbols into octets, first symbol in the low nibble.
// Assumes: sym_take is already qualified by lock and by frame_end.
module octet_pairer #(
    parameter int SYM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_take,
    input  logic [SYM_W-1:0]   sym_data,
    input  logic               flush,
    output logic               octet_valid,
    output logic [2*SYM_W-1:0] octet_data
);
    logic             have_low;
    logic [SYM_W-1:0] low_sym;

    // Hold the first half, emit the octet when the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_low    <= 1'b0;
            low_sym     <= '0;
            octet_valid <= 1'b0;
            octet_data  <= '0;
        end else begin
            octet_valid <= 1'b0;
            if (flush) begin
                have_low <= 1'b0;
            end else if (sym_take) begin
                if (have_low) begin
                    octet_data  <= {sym_data, low_sym};
                    octet_valid <= 1'b1;
                    have_low    <= 1'b0;
                end else begin
                    low_sym  <= sym_data;
                    have_low <= 1'b1;
                end
            end
        end
    end

    // R5
    pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        octet_valid |=> !octet_valid);
endmodule

// File: rtl/stamp_latch.sv
// Captures the symbol counter on a delimiter match and flags the capture.
// Assumes: capture has priority over acknowledge in the same cycle.
module stamp_latch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] sym_count,
    input  logic             stamp_ack,
    output logic [CNT_W-1:0] stamp_value,
    output logic             stamp_valid
);
    // Latch the counter and manage the capture-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_value <= '0;
            stamp_valid <= 1'b0;
        end else if (capture) begin
            stamp_value <= sym_count;
            stamp_valid <= 1'b1;
        end else if (stamp_ack) begin
            stamp_valid <= 1'b0;
        end
    end

    // R8
    capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (stamp_valid && stamp_value == $past(sym_count)));
    // R9
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(stamp_value));
    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_ack && !capture) |=> !stamp_valid);
endmodule

// File: rtl/frame_delim_sync.sv
// Top: delimiter search, octet alignment and timestamp capture.
// Assumes: symbols arrive after preamble lock; sym_count runs freely.
module frame_delim_sync #(
    parameter int         SYM_W     = 4,
    parameter int         CNT_W     = 32,
    parameter logic [7:0] DELIM_RST = 8'hA7,
    localparam int        OCT_W     = 2 * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             cfg_wr,
    input  logic [OCT_W-1:0] cfg_octet,
    input  logic             stamp_en,
    input  logic [CNT_W-1:0] sym_count,
    input  logic             stamp_ack,
    input  logic             frame_end,
    output logic             frame_start,
    output logic             octet_valid,
    output logic [OCT_W-1:0] octet_data,
    output logic [CNT_W-1:0] stamp_value,
    output logic             stamp_valid
);
    logic [OCT_W-1:0] delim;
    logic             match_now, locked;

    delim_cfg_reg #(.OCT_W(OCT_W), .DELIM_RST(DELIM_RST)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_octet(cfg_octet),
        .delim(delim));

    delim_hunter #(.SYM_W(SYM_W)) i_hunt (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
        .delim(delim), .frame_end(frame_end), .match_now(match_now),
        .locked(locked), .frame_start(frame_start));

    octet_pairer #(.SYM_W(SYM_W)) i_pair (
        .clk(clk), .rst_n(rst_n),
        .sym_take(sym_valid && locked && !frame_end), .sym_data(sym_data),
        .flush(frame_end), .octet_valid(octet_valid), .octet_data(octet_data));

    stamp_latch #(.CNT_W(CNT_W)) i_stamp (
        .clk(clk), .rst_n(rst_n), .capture(match_now && stamp_en),
        .sym_count(sym_count), .stamp_ack(stamp_ack),
        .stamp_value(stamp_value), .stamp_valid(stamp_valid));

    // R5
    start_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !octet_valid);
endmodule

// File: tb/test_frame_delim_sync.sv
module test_frame_delim_sync;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  sym_data = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_octet = '0;
    logic        stamp_en = 1'b0;
    logic [31:0] sym_count = '0;
    logic        stamp_ack = 1'b0;
    logic        frame_end = 1'b0;
    logic        frame_start, octet_valid, stamp_valid;
    logic [7:0]  octet_data;
    logic [31:0] stamp_value;
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_delim_sync i_frame_delim_sync (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
        .cfg_wr(cfg_wr), .cfg_octet(cfg_octet), .stamp_en(stamp_en),
        .sym_count(sym_count), .stamp_ack(stamp_ack), .frame_end(frame_end),
        .frame_start(frame_start), .octet_valid(octet_valid),
        .octet_data(octet_data), .stamp_value(stamp_value),
        .stamp_valid(stamp_valid));

    // Vector: {frame_end, valid, symbol, exp_start, exp_oct_valid, exp_octet}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},  // R2 first symbol
        {1'b0,1'b1,4'h5,1'b0,1'b0,8'h00},  // R3/R4 mismatch -> search
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},
        {1'b0,1'b0,4'hA,1'b0,1'b0,8'h00},  // R11 idle with second-symbol value
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},  // R3 retest as first
        {1'b0,1'b1,4'hA,1'b1,1'b0,8'h00},  // R2 match
        {1'b0,1'b1,4'h3,1'b0,1'b0,8'h00},
        {1'b0,1'b1,4'hC,1'b0,1'b1,8'hC3},  // R5 octet low-first
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},
        {1'b0,1'b1,4'hA,1'b0,1'b1,8'hA7},  // R5 delimiter pattern as data
        {1'b1,1'b1,4'h1,1'b0,1'b0,8'h00},  // R6 frame_end wins
        {1'b0,1'b1,4'hA,1'b0,1'b0,8'h00},  // searching again
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},
        {1'b0,1'b1,4'hA,1'b1,1'b0,8'h00},  // R2 new frame
        {1'b0,1'b1,4'h5,1'b0,1'b0,8'h00},  // half octet pending
        {1'b1,1'b0,4'h0,1'b0,1'b0,8'h00},  // R6 discard half
        {1'b0,1'b1,4'h7,1'b0,1'b0,8'h00},
        {1'b0,1'b1,4'hA,1'b1,1'b0,8'h00},
        {1'b0,1'b1,4'h6,1'b0,1'b0,8'h00},
        {1'b0,1'b1,4'hB,1'b0,1'b1,8'hB6},  // R6 pairing restarted cleanly
        {1'b0,1'b1,4'hE,1'b0,1'b0,8'h00},
        {1'b1,1'b0,4'h0,1'b0,1'b0,8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs at the falling edge, sample just after the rising edge.
    task automatic drive(input logic fe, input logic v, input logic [3:0] s);
        @(negedge clk);
        frame_end = fe; sym_valid = v; sym_data = s;
        @(posedge clk);
        #1;
        frame_end = 1'b0; sym_valid = 1'b0; stamp_ack = 1'b0; cfg_wr = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check("R1 frame_start", {31'd0, frame_start}, 32'd0);
        check("R1 octet_valid", {31'd0, octet_valid}, 32'd0);
        check("R1 stamp_valid", {31'd0, stamp_valid}, 32'd0);
        check("R1 stamp_value", stamp_value, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][15], VEC[i][14], VEC[i][13:10]);
            check($sformatf("R2 start vec%0d", i), {31'd0, frame_start}, {31'd0, VEC[i][9]});
            check($sformatf("R5 oct_valid vec%0d", i), {31'd0, octet_valid}, {31'd0, VEC[i][8]});
            if (VEC[i][8])
                check($sformatf("R5 octet vec%0d", i), {24'd0, octet_data}, {24'd0, VEC[i][7:0]});
        end
        check("R9 no capture while disabled", stamp_value, 32'd0);
        check("R9 flag idle while disabled", {31'd0, stamp_valid}, 32'd0);

        // Timestamp capture
        stamp_en = 1'b1; sym_count = 32'hDEAD_0001;
        drive(1'b0, 1'b1, 4'h7);
        sym_count = 32'h1234_5678;
        drive(1'b0, 1'b1, 4'hA);
        check("R8 start with stamp", {31'd0, frame_start}, 32'd1);
        check("R8 stamp value", stamp_value, 32'h1234_5678);
        check("R8 stamp valid", {31'd0, stamp_valid}, 32'd1);
        drive(1'b1, 1'b0, 4'h0);
        stamp_en = 1'b0; sym_count = 32'h0000_0BAD;
        drive(1'b0, 1'b1, 4'h7);
        drive(1'b0, 1'b1, 4'hA);
        check("R9 start while disabled", {31'd0, frame_start}, 32'd1);
        check("R9 stamp held", stamp_value, 32'h1234_5678);
        stamp_ack = 1'b1;
        drive(1'b0, 1'b0, 4'h0);
        check("R10 ack clears", {31'd0, stamp_valid}, 32'd0);
        check("R9 ack keeps value", stamp_value, 32'h1234_5678);
        drive(1'b1, 1'b0, 4'h0);
        stamp_en = 1'b1;
        drive(1'b0, 1'b1, 4'h7);
        stamp_ack = 1'b1; sym_count = 32'hCAFE_0002;
        drive(1'b0, 1'b1, 4'hA);
        check("R10 capture beats ack", {31'd0, stamp_valid}, 32'd1);
        check("R8 second capture", stamp_value, 32'hCAFE_0002);

        // Reprogram delimiter to 0x3C: first symbol C, second 3
        drive(1'b1, 1'b0, 4'h0);
        cfg_octet = 8'h3C; cfg_wr = 1'b1;
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b1, 4'h7);
        drive(1'b0, 1'b1, 4'hA);
        check("R7 old delimiter rejected", {31'd0, frame_start}, 32'd0);
        drive(1'b0, 1'b1, 4'h3);
        drive(1'b0, 1'b1, 4'hC);
        check("R4 reversed order rejected", {31'd0, frame_start}, 32'd0);
        drive(1'b0, 1'b1, 4'h3);
        check("R7 new delimiter accepted", {31'd0, frame_start}, 32'd1);
        drive(1'b0, 1'b1, 4'h9);
        drive(1'b0, 1'b1, 4'h4);
        check("R5 octet after new delimiter", {23'd0, octet_valid, octet_data}, {23'd0, 1'b1, 8'h49});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule